// File: doc/BRIEF.md
# Control-Bus Register Bank with Power-On Status

This block is the serial control port of a display-processor core. A two-wire host bus (I2C), sampled in the core clock domain, writes a bank of twenty byte-wide control registers and reads back one status byte. A write transfer carries a subaddress byte followed by any number of data bytes. The pointer advances by one after each data byte, so the host can refresh the whole bank in a single burst.

The status byte reports a sticky power-on flag, a deflection-fault input, an S-video sync-detect input and a signal-identification input. The power-on flag tells the host that the core has restarted and that every control register must be sent again. The block notes which registers have been written since reset. Once all twenty have been written, it raises a one-cycle pulse that downstream logic uses to start oscillator calibration, and it then begins counting a fresh refresh.

Top module: `ctlbus_regbank`

## Requirements
- R1: The block acknowledges a transfer only when the seven address bits are 1000101 (8A hex to write, 8B hex to read). Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R2: In a write transfer the first data byte is the subaddress. The next byte is stored in register k = subaddress and appears on `regs_o[8k+7:8k]` for k in 0..19. Every byte is acknowledged.
- R3: After each stored byte the pointer advances by one. Once it reaches 13 hex it stops there, and any further bytes in the same transfer overwrite register 13 hex.
- R4: A subaddress above 13 hex, including the test code FE hex, is acknowledged together with all of its data bytes. None of those bytes changes any register, and the pointer does not move.
- R5: Each byte of a read transfer is the current status: bit 7 is the power-on flag, bit 6 is `defl_fault_i`, bit 5 is `svid_sync_i`, bit 4 is `sig_ident_i`, and bits 3..0 are zero. While the master acknowledges, the bytes keep coming, each one current.
- R6: Reset sets the power-on flag to 1. The flag clears once the first status byte has been fully clocked out, at the master's acknowledge clock. Only reset sets it again.
- R7: Each register written since reset or since the last pulse is recorded. When the record covers all twenty registers, `all_written_o` is high for exactly one cycle and the record is cleared.
- R8: After reset all registers read 0, `sda_oe_o` is low and `all_written_o` is low.
- R9: A repeated START ends a write and begins a new addressed transfer without a STOP. A STOP returns the port to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | High pulls the data line low |
| defl_fault_i | input | 1 | Deflection fault status |
| svid_sync_i | input | 1 | Sync seen on S-video luminance |
| sig_ident_i | input | 1 | Video signal identified |
| regs_o | output | 160 | Register contents, register k at bits 8k+7..8k |
| all_written_o | output | 1 | One-cycle pulse when every register has been refreshed |

## Verification
The hardest case to reach is the completion pulse landing on the right write. The twenty-register record can be filled across many separate transfers, some of them discarded, and a burst that stops at register 13 hex can refill the same bit many times. The bench keeps its own model of the record and of the pointer, advancing both through single writes, full bursts, overrun bursts and discarded subaddresses. After every transfer it compares the number of pulses seen so far with the number its model predicts.

// File: rtl/ctlbus_pkg.sv
package ctlbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_SUB,
        ST_SACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e    st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] ptr;
        logic       rw;
        logic       mack;
        logic       drive;
        logic       wr_en;
        logic [7:0] wr_addr;
        logic [7:0] wr_data;
        logic       rd_done;
    } fsm_s;

endpackage

// File: rtl/ctlbus_pinsync.sv
module ctlbus_pinsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_s;

    sync_s q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s    = q.scl_pipe[STAGES-1];
    assign sda_s    = q.sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~q.scl_prev;
    assign scl_fall = ~scl_s & q.scl_prev;
    assign start_ev = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_ev  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/ctlbus_fsm.sv
module ctlbus_fsm
    import ctlbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h45,
    parameter logic [7:0] LAST_SUB = 8'h13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [7:0] status,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       rd_done
);
    fsm_s q, d;

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.rd_done = 1'b0;
        if (stop_ev) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else if (start_ev) begin
            d.st    = ST_ADDR;
            d.cnt   = 4'd0;
            d.drive = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == DEV_ADDR) begin
                                d.rw    = q.sh[0];
                                d.drive = 1'b1;
                                d.st    = ST_AACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end else if (q.st == ST_SUB) begin
                            d.ptr   = q.sh;
                            d.drive = 1'b1;
                            d.st    = ST_SACK;
                        end else begin
                            d.wr_en   = 1'b1;
                            d.wr_addr = q.ptr;
                            d.wr_data = q.sh;
                            d.drive   = 1'b1;
                            d.st      = ST_WACK;
                            if (q.ptr < LAST_SUB) d.ptr = q.ptr + 8'd1;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = 4'd0;
                        if (q.rw) begin
                            d.st    = ST_RD;
                            d.sh    = status;
                            d.drive = ~status[7];
                        end else begin
                            d.st    = ST_SUB;
                            d.drive = 1'b0;
                        end
                    end
                end
                ST_SACK, ST_WACK: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.cnt   = 4'd0;
                        d.st    = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise && q.cnt < 4'd8) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.drive = 1'b0;
                            d.st    = ST_RACK;
                        end else if (q.cnt != 4'd0) begin
                            d.drive = ~q.sh[3'd7 - q.cnt[2:0]];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.mack    = ~sda_s;
                        d.rd_done = 1'b1;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st    = ST_RD;
                            d.cnt   = 4'd0;
                            d.sh    = status;
                            d.drive = ~status[7];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.drive = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.drive;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_done = q.rd_done;
endmodule

// File: rtl/ctlbus_regstore.sv
module ctlbus_regstore #(
    parameter int NREG = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_done,
    input  logic              defl_fault,
    input  logic              svid_sync,
    input  logic              sig_ident,
    output logic [7:0]        status,
    output logic [NREG*8-1:0] regs,
    output logic [NREG-1:0]   mask,
    output logic              por,
    output logic              all_written
);
    localparam int         IDXW   = $clog2(NREG);
    localparam logic [7:0] NREG_B = 8'(NREG);

    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
        logic [NREG-1:0]      mask;
        logic                 por;
        logic                 pulse;
    } store_s;

    store_s q, d;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (rd_done) d.por = 1'b0;
        if (wr_en && wr_addr < NREG_B) begin
            d.regs[wr_addr[IDXW-1:0]] = wr_data;
            d.mask[wr_addr[IDXW-1:0]] = 1'b1;
        end
        if (&d.mask) begin
            d.pulse = 1'b1;
            d.mask  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.por <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign status      = {q.por, defl_fault, svid_sync, sig_ident, 4'b0000};
    assign regs        = q.regs;
    assign mask        = q.mask;
    assign por         = q.por;
    assign all_written = q.pulse;
endmodule

// File: rtl/ctlbus_regbank.sv
module ctlbus_regbank #(
    parameter logic [6:0] DEV_ADDR    = 7'h45,
    parameter int         NREG        = 20,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              defl_fault_i,
    input  logic              svid_sync_i,
    input  logic              sig_ident_i,
    output logic [NREG*8-1:0] regs_o,
    output logic              all_written_o
);
    localparam logic [7:0] LAST_SUB = 8'(NREG - 1);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_en, rd_done, por;
    logic [7:0] wr_addr, wr_data, status;
    logic [NREG-1:0] wr_mask;

    ctlbus_pinsync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    ctlbus_fsm #(.DEV_ADDR(DEV_ADDR), .LAST_SUB(LAST_SUB)) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .status(status), .sda_oe(sda_oe_o), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_done(rd_done)
    );

    ctlbus_regstore #(.NREG(NREG)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_done(rd_done), .defl_fault(defl_fault_i),
        .svid_sync(svid_sync_i), .sig_ident(sig_ident_i), .status(status),
        .regs(regs_o), .mask(wr_mask), .por(por), .all_written(all_written_o)
    );
endmodule

// File: rtl/ctlbus_regbank_chk.sv
module ctlbus_regbank_chk #(
    parameter int NREG = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [NREG*8-1:0] regs,
    input logic [NREG-1:0]   mask,
    input logic              por,
    input logic              all_written
);
    localparam logic [7:0] NREG_B = 8'(NREG);

    AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe)); // R1
    AST_REGS_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs)); // R2
    AST_DISCARD_HIGH_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= NREG_B) |=> $stable(regs)); // R4
    AST_POR_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(por)); // R6
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        all_written |=> !all_written); // R7
    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        all_written |-> (mask == '0)); // R7
endmodule

bind ctlbus_regbank ctlbus_regbank_chk #(.NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_oe(sda_oe_o), .wr_en(wr_en), .wr_addr(wr_addr),
    .regs(regs_o), .mask(wr_mask), .por(por), .all_written(all_written_o)
);

// File: tb/ctlbus_regbank_tb.sv
module ctlbus_regbank_tb_top;
    localparam int NREG = 20;
    localparam int H    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic fault = 1'b0, svid = 1'b0, ident = 1'b0;
    logic [NREG*8-1:0] regs;
    logic all_written;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0, pulses = 0, exp_pulses = 0;
    logic [7:0] exp_regs [NREG];
    logic [NREG-1:0] exp_mask = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctlbus_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .defl_fault_i(fault), .svid_sync_i(svid),
        .sig_ident_i(ident), .regs_o(regs), .all_written_o(all_written)
    );

    always @(posedge clk) if (rst_n && all_written) pulses <= pulses + 1;

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bstart();
        sda_m = 1'b1; wt(2); scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(2);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    task automatic sendb(logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
        end
        sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H / 2);
        ack = ~sda_line; wt(H / 2); scl_m = 1'b0; wt(2);
    endtask

    task automatic recvb(logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H); scl_m = 1'b1; wt(H / 2); b[i] = sda_line; wt(H / 2);
            scl_m = 1'b0; wt(2);
        end
        sda_m = ~mack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
        sda_m = 1'b1;
    endtask

    function automatic void model_wr(ref logic [7:0] ptr, input logic [7:0] b);
        if (ptr < 8'(NREG)) begin
            exp_regs[ptr] = b;
            exp_mask[ptr] = 1'b1;
            if (&exp_mask) begin exp_pulses++; exp_mask = '0; end
        end
        if (ptr < 8'(NREG - 1)) ptr = ptr + 8'd1;
    endfunction

    // write n bytes from seed, data byte i = seed + 29*i
    task automatic wr_burst(string req, logic [7:0] sub, int n, logic [7:0] seed);
        logic ack;
        logic [7:0] ptr = sub;
        int nack = 0;
        bstart();
        sendb(8'h8A, ack); if (!ack) nack++;
        sendb(sub, ack);   if (!ack) nack++;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = seed + 8'(29 * i);
            sendb(b, ack); if (!ack) nack++;
            model_wr(ptr, b);
        end
        bstop(); wt(6);
        chk({req, " ack"}, nack, 0);
    endtask

    task automatic chk_regs(string req);
        int bad = 0;
        for (int k = 0; k < NREG; k++)
            if (regs[k*8 +: 8] !== exp_regs[k]) begin
                bad++;
                $display("FAIL %s reg%0d actual=%0h expected=%0h", req, k, regs[k*8 +: 8], exp_regs[k]);
            end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic rd_status(int n, output logic [7:0] b0, output logic [7:0] b1, output logic ack);
        bstart();
        sendb(8'h8B, ack);
        recvb(n > 1, b0);
        b1 = 8'h00;
        if (n > 1) recvb(1'b0, b1);
        bstop(); wt(6);
    endtask

    initial begin
        logic ack;
        logic [7:0] s0, s1;
        for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
        wt(5); rst_n = 1'b1; wt(5);

        // R8 reset state
        chk("R8 oe", 32'(sda_oe), 0);
        chk("R8 pulse", 32'(all_written), 0);
        chk_regs("R8 regs");

        // R1 wrong address: no ack, nothing written
        bstart(); sendb(8'h90, ack); chk("R1 no ack", 32'(ack), 0);
        sendb(8'h03, ack); sendb(8'hFF, ack); bstop(); wt(6);
        chk_regs("R1 ignored");

        // R6 / R5 POR visible once, then cleared; two bytes in one read
        fault = 1'b1;
        rd_status(2, s0, s1, ack);
        chk("R1 read ack", 32'(ack), 1);
        chk("R6 por first", 32'(s0), 32'h0C0);
        chk("R5 second byte", 32'(s1), 32'h040);
        rd_status(1, s0, s1, ack);
        chk("R6 por stays clear", 32'(s0), 32'h040);

        // R5 status sweep
        for (int c = 0; c < 8; c++) begin
            {fault, svid, ident} = 3'(c);
            rd_status(1, s0, s1, ack);
            chk("R5 status", 32'(s0), 32'(c << 4));
        end

        // R2 single writes to each subaddress; R7 pulse only after the last
        for (int k = 0; k < NREG; k++) begin
            wr_burst("R2 single", 8'(k), 1, 8'(k * 37 + 5));
            if (k == NREG - 2) chk("R7 no early pulse", pulses, 0);
        end
        chk_regs("R2 all regs");
        chk("R7 pulse after full refresh", pulses, exp_pulses);

        // R3 full burst
        wr_burst("R3 burst", 8'h00, NREG, 8'h11);
        chk_regs("R3 burst regs");
        chk("R7 second pulse", pulses, exp_pulses);

        // R3 overrun stops at 13 hex
        wr_burst("R3 overrun", 8'h12, 4, 8'hA0);
        chk_regs("R3 overrun regs");
        chk("R3 reg13", 32'(regs[19*8 +: 8]), 32'(8'hA0 + 8'(29 * 3)));

        // R4 test code and out-of-range subaddresses
        wr_burst("R4 FE", 8'hFE, 3, 8'h55);
        wr_burst("R4 14", 8'h14, 2, 8'h66);
        wr_burst("R4 7F", 8'h7F, 1, 8'h77);
        chk_regs("R4 unchanged");

        // R9 repeated start: write then read without stop
        bstart(); sendb(8'h8A, ack); sendb(8'h05, ack); sendb(8'h5A, ack);
        begin logic [7:0] p = 8'h05; model_wr(p, 8'h5A); end
        bstart(); sendb(8'h8B, ack);
        chk("R9 ack after restart", 32'(ack), 1);
        recvb(1'b0, s0); bstop(); wt(6);
        chk("R9 status", 32'(s0), 32'(({fault, svid, ident}) << 4));
        chk_regs("R9 regs");

        // R7 refresh across many transfers in reverse order
        for (int k = NREG - 1; k >= 0; k--) wr_burst("R7 reverse", 8'(k), 1, 8'(k ^ 8'hC3));
        chk_regs("R7 reverse regs");
        chk("R7 pulse count", pulses, exp_pulses);
        chk("R8 oe idle", 32'(sda_oe), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule